// File: doc/BRIEF.md
# Byte-Packing Card Data FIFO Engine

This block sits between a host register interface and the byte-wide data lines of a memory card controller. Data passes through a 16-entry FIFO of 32-bit words. A transfer starts when the host writes the control register with its enable bit set. That write copies the programmed length into a byte counter. The direction bit picks which way data moves.

In the card-to-host direction, incoming card bytes are packed little-endian into words and pushed into the FIFO, which the host drains through a data window. In the host-to-card direction, the host fills the FIFO and each word is sent to the card one byte at a time, lowest byte first. At most one byte crosses the card side per clock. The engine keeps the FIFO status flags and a sticky data-end indication. It also implements a refill hold: once the host has popped a word, card intake pauses until the host next polls the status or count register.

Register word addresses: 0 is length, 1 is control, 2 is status, 3 is the word count, and 16 to 31 form the FIFO data window.

Top module: `card_fifo_engine`

## Requirements
- R1: The FIFO holds 16 words. A push while it holds 16 is ignored. A host read of the data window while the FIFO is empty returns 0 and leaves the level unchanged. In the card-to-host direction, the card ready output is low while the FIFO is full.
- R2: A write to address 0 stores only data bits 15:0, and a read returns them zero-extended. A write to address 1 stores bits 7:0: bit 0 enable, bit 1 direction (1 = card to FIFO), bit 2 mode, bit 3 DMA enable. Reading address 1 returns the stored byte.
- R3: A control write with bit 0 set loads the byte counter from the length register. The counter then drops by exactly one for each byte moved, with at most one byte per clock.
- R4: In the card-to-FIFO direction, the first byte of each word lands in bits 7:0 and later bytes fill upward. A word left partly filled when the counter reaches zero is still pushed, with its unfilled bytes zero.
- R5: In the FIFO-to-card direction, each word is sent lowest byte first. A word leaves the FIFO after its fourth byte, or after the byte that brings the counter to zero.
- R6: While enabled with the counter at zero, status bits 8 and 10 are set one clock later. They stay set until the next enabling control write.
- R7: While enabled with both the counter and the FIFO level at zero, control bit 0 clears one clock later.
- R8: Status at address 2 holds the FIFO flags while control bit 0 is set. For direction 1: bit 13 active, bit 15 level >= 8, bit 17 level = 16, bit 19 level = 0, bit 21 level > 0. For direction 0: bit 12 active, bit 14 level <= 8, bit 16 level = 16, bit 18 level = 0, bit 20 level > 0. All of bits 12 to 21 read 0 while bit 0 is clear.
- R9: A host read of the data window that pops a word sets a hold that keeps card ready low. A read of address 2 or address 3 clears the hold.
- R10: Address 3 reads as (remaining byte count + 3) / 4.
- R11: Every address from 16 to 31 reaches the same FIFO port. A host write there while the byte counter is zero is dropped.
- R12: After reset, all registers read 0, and card ready and card valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_rd | input | 1 | Host read strobe; side effects apply at the clock edge |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 6 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from the address |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from card |
| card_rx_ready | output | 1 | Engine accepts a card byte this cycle |
| card_tx_valid | output | 1 | Engine offers a byte to the card |
| card_tx_data | output | 8 | Byte to card |
| card_tx_ready | input | 1 | Card accepts the offered byte |

## Verification
The hardest state to reach is the refill hold while the card side still has data to deliver. It needs a card-to-FIFO transfer long enough to fill all 16 words, then a host pop that leaves free space while intake stays blocked. The stimulus fills the FIFO, pops one word, and checks that ready stays low with a free slot. It then releases the hold through a status poll, refills, and drains in stages, with a count-register poll as the second release path. A host-to-card run with the card stalled pushes a 17th word to show the overflow is dropped, and a 10-byte run ends on a half word.

// File: rtl/card_fifo_pkg.sv
package card_fifo_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned CTL_W  = 8;

  // status bit positions (software decodes these)
  localparam int unsigned ST_DATA_END  = 8;
  localparam int unsigned ST_BLOCK_END = 10;
  localparam int unsigned ST_TX_ACT    = 12;
  localparam int unsigned ST_RX_ACT    = 13;
  localparam int unsigned ST_TX_HALF   = 14;
  localparam int unsigned ST_RX_HALF   = 15;
  localparam int unsigned ST_TX_FULL   = 16;
  localparam int unsigned ST_RX_FULL   = 17;
  localparam int unsigned ST_TX_EMPTY  = 18;
  localparam int unsigned ST_RX_EMPTY  = 19;
  localparam int unsigned ST_TX_AVAIL  = 20;
  localparam int unsigned ST_RX_AVAIL  = 21;

  localparam int unsigned CTL_EN  = 0;
  localparam int unsigned CTL_DIR = 1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LEN, SEL_CTL, SEL_STAT, SEL_CNT, SEL_FIFO
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1:4] == 2'b01) return SEL_FIFO;
    case (a)
      6'd0:    return SEL_LEN;
      6'd1:    return SEL_CTL;
      6'd2:    return SEL_STAT;
      6'd3:    return SEL_CNT;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/card_word_fifo.sv
// Word FIFO; DEPTH must be a power of two so pointers wrap naturally.
module card_word_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [LVL_W-1:0] level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic push_ok, pop_ok;

  assign push_ok = push && (level_q != LVL_W'(DEPTH));
  assign pop_ok  = pop && (level_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (push_ok) wr_ptr_d = wr_ptr_q + PTR_W'(1);
    if (pop_ok)  rd_ptr_d = rd_ptr_q + PTR_W'(1);
    if (push_ok && !pop_ok) level_d = level_q + LVL_W'(1);
    if (pop_ok && !push_ok) level_d = level_q - LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data;
  end

  assign head  = mem[rd_ptr_q];
  assign level = level_q;

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_W'(DEPTH));
  assert_full_push_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && level_q == LVL_W'(DEPTH)) |=> level_q == LVL_W'(DEPTH));
  assert_empty_pop_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && level_q == '0) |=> level_q == '0);
endmodule

// File: rtl/rx_byte_packer.sv
// Gathers card bytes into a word, lowest lane first.
module rx_byte_packer #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned LANES  = WORD_W / 8,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              take,
  input  logic              last,
  input  logic [7:0]        byte_in,
  output logic [WORD_W-1:0] word_out,
  output logic              word_push
);
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [WORD_W-1:0] acc_q, acc_d;

  always_comb begin
    word_out = acc_q;
    word_out[{lane_q, 3'b000} +: 8] = byte_in;
  end

  assign word_push = take && ((lane_q == LANE_W'(LANES - 1)) || last);

  always_comb begin
    lane_d = lane_q;
    acc_d  = acc_q;
    if (restart) begin
      lane_d = '0;
      acc_d  = '0;
    end else if (take) begin
      if (word_push) begin
        lane_d = '0;
        acc_d  = '0;
      end else begin
        lane_d = lane_q + LANE_W'(1);
        acc_d  = word_out;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else begin
      lane_q <= lane_d;
      acc_q  <= acc_d;
    end
  end

  assert_pack_fresh_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_push && !restart) |=> acc_q == '0);
endmodule

// File: rtl/tx_byte_unpacker.sv
// Walks the FIFO head word one byte lane at a time, lowest first.
module tx_byte_unpacker #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned LANES  = WORD_W / 8,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              give,
  input  logic              last,
  input  logic [WORD_W-1:0] head_word,
  output logic [7:0]        byte_out,
  output logic              word_pop
);
  logic [LANE_W-1:0] lane_q, lane_d;

  assign byte_out = head_word[{lane_q, 3'b000} +: 8];
  assign word_pop = give && ((lane_q == LANE_W'(LANES - 1)) || last);

  always_comb begin
    lane_d = lane_q;
    if (restart)       lane_d = '0;
    else if (word_pop) lane_d = '0;
    else if (give)     lane_d = lane_q + LANE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= lane_d;
  end

  assert_unpack_lane_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!give && !restart) |=> $stable(lane_q));
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine
  import card_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              card_rx_valid,
  input  logic [7:0]        card_rx_data,
  output logic              card_rx_ready,
  output logic              card_tx_valid,
  output logic [7:0]        card_tx_data,
  input  logic              card_tx_ready
);
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1;
  localparam int unsigned HALF  = DEPTH / 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_q1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  logic [LEN_W-1:0] len_q, len_d, cnt_q, cnt_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             end_q, end_d, hold_q, hold_d;

  reg_sel_e sel;
  logic wr_len, wr_ctl, wr_fifo, rd_stat, rd_cnt, rd_fifo, ctl_load;
  logic en, dir_rx, cnt_zero, cnt_last;
  logic [LVL_W-1:0]  level;
  logic [WORD_W-1:0] head, pack_word, push_data;
  logic fifo_empty, fifo_full, rx_take, tx_give, pack_push, unpack_pop;
  logic fifo_push, fifo_pop;
  logic [WORD_W-1:0] status_w, count_w;
  logic [LEN_W:0]    cnt_plus;

  assign sel      = decode_addr(host_addr);
  assign wr_len   = host_wr && (sel == SEL_LEN);
  assign wr_ctl   = host_wr && (sel == SEL_CTL);
  assign wr_fifo  = host_wr && (sel == SEL_FIFO);
  assign rd_stat  = host_rd && (sel == SEL_STAT);
  assign rd_cnt   = host_rd && (sel == SEL_CNT);
  assign rd_fifo  = host_rd && (sel == SEL_FIFO);
  assign ctl_load = wr_ctl && host_wdata[CTL_EN];

  assign en         = ctl_q[CTL_EN];
  assign dir_rx     = ctl_q[CTL_DIR];
  assign cnt_zero   = (cnt_q == '0);
  assign cnt_last   = (cnt_q == LEN_W'(1));
  assign fifo_empty = (level == '0);
  assign fifo_full  = (level == LVL_W'(DEPTH));

  // card side handshakes, one byte per clock at most
  assign card_rx_ready = en && dir_rx && !cnt_zero && !hold_q && !fifo_full;
  assign rx_take       = card_rx_valid && card_rx_ready;
  assign card_tx_valid = en && !dir_rx && !cnt_zero && !fifo_empty;
  assign tx_give       = card_tx_valid && card_tx_ready;

  rx_byte_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_sync_n), .restart(ctl_load), .take(rx_take),
    .last(cnt_last), .byte_in(card_rx_data), .word_out(pack_word),
    .word_push(pack_push)
  );

  tx_byte_unpacker #(.WORD_W(WORD_W)) u_unpack (
    .clk(clk), .rst_n(rst_sync_n), .restart(ctl_load), .give(tx_give),
    .last(cnt_last), .head_word(head), .byte_out(card_tx_data),
    .word_pop(unpack_pop)
  );

  // packed card words take precedence over a host write in the same cycle
  assign fifo_push = pack_push || (wr_fifo && !cnt_zero);
  assign push_data = pack_push ? pack_word : host_wdata;
  assign fifo_pop  = unpack_pop || rd_fifo;

  card_word_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n), .push(fifo_push), .push_data(push_data),
    .pop(fifo_pop), .head(head), .level(level)
  );

  // status word
  always_comb begin
    status_w = '0;
    status_w[ST_DATA_END]  = end_q;
    status_w[ST_BLOCK_END] = end_q;
    if (en) begin
      if (dir_rx) begin
        status_w[ST_RX_ACT]   = 1'b1;
        status_w[ST_RX_HALF]  = (level >= LVL_W'(HALF));
        status_w[ST_RX_FULL]  = fifo_full;
        status_w[ST_RX_EMPTY] = fifo_empty;
        status_w[ST_RX_AVAIL] = !fifo_empty;
      end else begin
        status_w[ST_TX_ACT]   = 1'b1;
        status_w[ST_TX_HALF]  = (level <= LVL_W'(HALF));
        status_w[ST_TX_FULL]  = fifo_full;
        status_w[ST_TX_EMPTY] = fifo_empty;
        status_w[ST_TX_AVAIL] = !fifo_empty;
      end
    end
  end

  assign cnt_plus = {1'b0, cnt_q} + (LEN_W+1)'(3);
  assign count_w  = WORD_W'(cnt_plus >> 2);

  always_comb begin
    unique case (sel)
      SEL_LEN:  host_rdata = WORD_W'(len_q);
      SEL_CTL:  host_rdata = WORD_W'(ctl_q);
      SEL_STAT: host_rdata = status_w;
      SEL_CNT:  host_rdata = count_w;
      SEL_FIFO: host_rdata = fifo_empty ? '0 : head;
      default:  host_rdata = '0;
    endcase
  end

  // next state
  always_comb begin
    len_d  = len_q;
    ctl_d  = ctl_q;
    cnt_d  = cnt_q;
    end_d  = end_q;
    hold_d = hold_q;
    if (wr_len) len_d = host_wdata[LEN_W-1:0];
    if (wr_ctl) ctl_d = host_wdata[CTL_W-1:0];
    else if (en && cnt_zero && fifo_empty) ctl_d[CTL_EN] = 1'b0;
    if (ctl_load) cnt_d = len_q;
    else if (rx_take || tx_give) cnt_d = cnt_q - LEN_W'(1);
    if (ctl_load) end_d = 1'b0;
    else if (en && cnt_zero) end_d = 1'b1;
    if (rd_stat || rd_cnt) hold_d = 1'b0;
    else if (rd_fifo && !fifo_empty) hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      len_q  <= '0;
      ctl_q  <= '0;
      cnt_q  <= '0;
      end_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      len_q  <= len_d;
      ctl_q  <= ctl_d;
      cnt_q  <= cnt_d;
      end_q  <= end_d;
      hold_q <= hold_d;
    end
  end

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctl_load |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - LEN_W'(1)));
  assert_one_byte_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({card_rx_ready, card_tx_valid}));
  assert_end_flags_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && cnt_zero && !wr_ctl) |=> (status_w[ST_DATA_END] && status_w[ST_BLOCK_END]));
  assert_auto_off_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && cnt_zero && fifo_empty && !wr_ctl) |=> !ctl_q[CTL_EN]);
  assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_fifo && !fifo_empty && !wr_ctl) |=> !card_rx_ready);
endmodule

// File: tb/card_fifo_engine_tb.sv
module card_fifo_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_rd, host_wr;
  logic [5:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        card_rx_valid, card_rx_ready;
  logic [7:0]  card_rx_data, card_tx_data;
  logic        card_tx_valid, card_tx_ready;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0]  exp_bytes[$];
  logic [31:0] exp_words[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  card_fifo_engine u_dut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
    .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
    .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // all host tasks start and end on a falling edge
  task automatic hwrite(input logic [5:0] a, input logic [31:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hread(input logic [5:0] a, output logic [31:0] d);
    host_rd = 1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic card_send(input logic [7:0] b);
    logic ok;
    card_rx_valid = 1; card_rx_data = b; ok = 0;
    while (!ok) begin
      #2 ok = card_rx_ready;
      @(negedge clk);
    end
    card_rx_valid = 0;
  endtask

  // scoreboard drivers
  task automatic expect_tx_word(input logic [31:0] w, input int nbytes);
    for (int k = 0; k < nbytes; k++) exp_bytes.push_back(w[8*k +: 8]);
  endtask

  task automatic read_fifo_word(input string tag);
    logic [31:0] d, e;
    hread(6'd16, d);
    e = (exp_words.size() > 0) ? exp_words.pop_front() : 32'hBAD0BAD0;
    chk(tag, d, e);
  endtask

  function automatic logic [31:0] ramp_word(input int j);
    return {8'(4*j+3), 8'(4*j+2), 8'(4*j+1), 8'(4*j)};
  endfunction

  // monitor: compare every byte the card takes against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (card_tx_valid && card_tx_ready) begin
        if (exp_bytes.size() == 0) chk("R5 unexpected card byte", {24'd0, card_tx_data}, 32'hFFFF_FFFF);
        else chk("R5 card byte order", {24'd0, card_tx_data}, {24'd0, exp_bytes.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; host_rd = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    card_rx_valid = 0; card_rx_data = 0; card_tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R12 reset state
    hread(6'd2, d); chk("R12 status", d, 0);
    hread(6'd1, d); chk("R12 control", d, 0);
    hread(6'd3, d); chk("R12 count", d, 0);
    chk("R12 rx ready", {31'd0, card_rx_ready}, 0);
    chk("R12 tx valid", {31'd0, card_tx_valid}, 0);

    // R2 field widths
    hwrite(6'd0, 32'h0001_2345);
    hread(6'd0, d); chk("R2 length 16 bits", d, 32'h2345);
    hwrite(6'd1, 32'h0000_03AC);
    hread(6'd1, d); chk("R2 control 8 bits", d, 32'hAC);
    hwrite(6'd1, 32'h0);

    // R6 R7 zero-length transfer
    hwrite(6'd0, 32'd0);
    hwrite(6'd1, 32'h1);
    @(negedge clk);
    hread(6'd2, d); chk("R6 end flags", d, 32'h500);
    hread(6'd1, d); chk("R7 enable cleared", d, 32'h0);

    // R11 write dropped with count zero; R1 empty read
    hwrite(6'd16, 32'hDEAD_BEEF);
    hread(6'd17, d); chk("R11 dropped write / R1 empty read", d, 0);

    // R5 R8 R10 host to card, 10 bytes ending in a half word
    card_tx_ready = 0;
    hwrite(6'd0, 32'd10);
    hwrite(6'd1, 32'h1);
    hread(6'd2, d); chk("R8 tx empty flags", d, 32'h0004_5000);
    hread(6'd3, d); chk("R10 count 10 bytes", d, 32'd3);
    expect_tx_word(32'h4433_2211, 4);
    expect_tx_word(32'h8877_6655, 4);
    expect_tx_word(32'hCCBB_AA99, 2);
    hwrite(6'd16, 32'h4433_2211);
    hwrite(6'd20, 32'h8877_6655);
    hwrite(6'd31, 32'hCCBB_AA99);
    hread(6'd2, d); chk("R8 R11 tx three words", d, 32'h0010_5000);
    card_tx_ready = 1;
    repeat (15) @(negedge clk);
    chk("R5 all bytes sent", exp_bytes.size(), 0);
    hread(6'd2, d); chk("R5 R7 tx done", d, 32'h500);
    hread(6'd3, d); chk("R10 count zero", d, 0);
    card_tx_ready = 0;

    // R4 card to host, 7 bytes
    exp_words.push_back(32'h0403_0201);
    exp_words.push_back(32'h0007_0605);
    hwrite(6'd0, 32'd7);
    hwrite(6'd1, 32'h3);
    for (int i = 1; i <= 7; i++) card_send(8'(i));
    @(negedge clk);
    hread(6'd2, d); chk("R4 R6 R8 rx status", d, 32'h0020_2500);
    read_fifo_word("R4 full word");
    read_fifo_word("R4 partial word");
    @(negedge clk);
    hread(6'd2, d); chk("R7 rx done", d, 32'h500);

    // R1 R9 full FIFO and hold
    for (int j = 0; j < 20; j++) exp_words.push_back(ramp_word(j));
    hwrite(6'd0, 32'd80);
    hwrite(6'd1, 32'h3);
    for (int i = 0; i < 64; i++) card_send(8'(i));
    #2 chk("R1 ready low when full", {31'd0, card_rx_ready}, 0);
    hread(6'd2, d); chk("R8 rx full flags", d, 32'h0022_A000);
    hread(6'd3, d); chk("R10 count 16 bytes", d, 32'd4);
    read_fifo_word("R9 first pop");
    #2 chk("R9 hold blocks ready", {31'd0, card_rx_ready}, 0);
    hread(6'd2, d); chk("R9 R8 status at 15", d, 32'h0020_A000);
    #2 chk("R9 status read releases", {31'd0, card_rx_ready}, 1);
    for (int i = 64; i < 68; i++) card_send(8'(i));
    for (int j = 0; j < 16; j++) read_fifo_word("R4 R9 drain");
    hread(6'd3, d); chk("R10 R9 count read releases", d, 32'd3);
    #2 chk("R9 count read releases", {31'd0, card_rx_ready}, 1);
    for (int i = 68; i < 80; i++) card_send(8'(i));
    for (int j = 0; j < 3; j++) read_fifo_word("R4 tail drain");
    @(negedge clk);
    hread(6'd2, d); chk("R7 long rx done", d, 32'h500);

    // R1 overflow on host side, card stalled
    hwrite(6'd0, 32'd80);
    hwrite(6'd1, 32'h1);
    for (int j = 0; j < 17; j++) begin
      if (j < 16) expect_tx_word(32'hA000_0000 + 32'(j), 4);
      hwrite(6'(16 + (j % 16)), 32'hA000_0000 + 32'(j));
    end
    hread(6'd2, d); chk("R8 tx full flags", d, 32'h0011_1000);
    card_tx_ready = 1;
    repeat (70) @(negedge clk);
    chk("R1 17th word dropped", exp_bytes.size(), 0);
    #2 chk("R1 no byte without data", {31'd0, card_tx_valid}, 0);
    hread(6'd3, d); chk("R10 R3 count after 64 bytes", d, 32'd4);
    card_tx_ready = 0;
    hwrite(6'd1, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule